// File: doc/BRIEF.md
# Debug Mailbox Channel

This block carries 32-bit words in both directions between an external debug host and software running on a processor core, while the core runs normally. It contains two independent word stores. The host fills the inbound store and the core empties it. The core fills the outbound store and the host empties it. A word can wait in each direction at the same time. Each store has a full flag. The core and the host both see the two flags. The core reads them from a status register, and the host reads them from dedicated status outputs.

The core reaches the block through a one-bit-address register port that carries a privilege qualifier. Address 0 is the data register: a read returns the inbound word and a write loads the outbound word. Address 1 is the status register. A user-access lock bit in the status register limits all core-side access to privileged accesses. A blocked access is answered with zero read data and a single-cycle error pulse, and it changes nothing.

The host side is a plain strobe interface. A write strobe loads the inbound word. A read strobe acknowledges the outbound word, which is always visible on the host read-data output. Both flags update on the clock edge where their strobes are sampled. Core read data is combinational from the current state.

Top module: `dcc_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, both words, both full flags, the user-access lock bit and `core_err` are cleared. After reset, a status read returns 0.
- R2: An unblocked core write to address 0 stores `core_wdata` in the outbound word and sets the outbound full flag, both from the next edge. The word appears on `host_rdata`.
- R3: A core write to address 0 while the outbound flag is already set replaces the stored word, and the flag stays set.
- R4: A host read strobe clears the outbound full flag at the next edge, unless an unblocked core data write occurs in the same cycle.
- R5: A host write strobe stores `host_wdata` in the inbound word and sets the inbound full flag, even if the flag is already set, in which case the word is overwritten. An unblocked core read of address 0 returns the inbound word and clears the flag.
- R6: A core read of address 0 while the inbound flag is clear returns the last stored inbound word, and the flag stays clear.
- R7: A core status read returns the inbound full flag in bit 30, the outbound full flag in bit 29, the lock bit in bit 12, and zero in all other bits. A core status write changes only the lock bit, which is loaded from `core_wdata[12]`.
- R8: While the lock bit is 1, a core access with `core_priv` low is blocked. It reads 0, it alters no word, flag or lock bit, and `core_err` is high for exactly the following cycle.
- R9: Privileged accesses while the lock bit is 1, and all accesses while it is 0, take effect normally with `core_err` low. `core_err` is low in any cycle that follows no blocked access.
- R10: When a set event and a clear event for the same flag fall in the same cycle, the flag ends up set. This applies to both flags.
- R11: The two directions are independent. Traffic in one direction never changes the word or the flag of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_en | input | 1 | Core access strobe |
| core_we | input | 1 | Core write (1) or read (0) |
| core_addr | input | 1 | 0 = data register, 1 = status register |
| core_priv | input | 1 | Access made by privileged software |
| core_wdata | input | 32 | Core write data |
| core_rdata | output | 32 | Core read data, combinational, 0 when not reading or blocked |
| core_err | output | 1 | One-cycle pulse after a blocked access |
| host_wr_en | input | 1 | Host write strobe for the inbound word |
| host_wdata | input | 32 | Host write data |
| host_rd_en | input | 1 | Host read acknowledge for the outbound word |
| host_rdata | output | 32 | Current outbound word |
| host_in_full | output | 1 | Inbound full flag |
| host_out_full | output | 1 | Outbound full flag |

## Verification
A flag stuck in the wrong state shows up on `host_in_full` or `host_out_full` one edge after the event that should have moved it, and it also appears in the next status read. A wrong stored word appears on `host_rdata` right after the edge that loads it, or on `core_rdata` during the next core data read. A wrong lock decision shows up in the same cycle as zero or non-zero read data, and one cycle later on `core_err`. The bench runs a reference model alongside the design over a long pseudo-random sweep of every strobe combination and compares all outputs on every cycle, so a divergence is reported within one cycle of its cause.

// File: rtl/dcc_pkg.sv
// Package: shared constants and types for the debug mailbox channel.
// Assumes status layout bits fit inside the data width (width >= 31).
package dcc_pkg;
    localparam int DCC_DATA_W   = 32;
    localparam int STAT_INF_BIT = 30;
    localparam int STAT_OUTF_BIT = 29;
    localparam int STAT_LOCK_BIT = 12;

    typedef enum logic [0:0] {
        SEL_DATA = 1'b0,
        SEL_STAT = 1'b1
    } dcc_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        dcc_sel_e sel;
        logic     blocked;
    } core_req_t;
endpackage

// File: rtl/dcc_slot.sv
// Module: one mailbox word with its full flag.
// A load writes the word and sets the flag; a take clears the flag.
// A load in the same cycle as a take wins. Assumes synchronous active-low reset.
module dcc_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         take,
    output logic [W-1:0] word,
    output logic         full
);
    // Word store: loaded on every load, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (load)
            word <= load_data;
    end

    // Full flag: the set has priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (load)
            full <= 1'b1;
        else if (take)
            full <= 1'b0;
    end
endmodule

// File: rtl/dcc_core_if.sv
// Module: core-side register port. Decodes data and status accesses,
// applies the user-access lock, builds the status word, and holds the lock bit
// and the error pulse. Assumes single-cycle accesses with a combinational read.
module dcc_core_if
    import dcc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         core_en,
    input  logic         core_we,
    input  logic         core_addr,
    input  logic         core_priv,
    input  logic [W-1:0] core_wdata,
    input  logic [W-1:0] in_word,
    input  logic         in_full,
    input  logic         out_full,
    output logic         out_load,
    output logic [W-1:0] out_data,
    output logic         in_take,
    output logic [W-1:0] core_rdata,
    output logic         core_err,
    output logic         lock
);
    core_req_t    req;
    logic [W-1:0] stat_word;

    // Decode the access and decide whether the lock blocks it.
    always_comb begin
        req.rd      = core_en && !core_we;
        req.wr      = core_en && core_we;
        req.sel     = dcc_sel_e'(core_addr);
        req.blocked = core_en && lock && !core_priv;
    end

    // Assemble the status word from the flags and the lock bit.
    always_comb begin
        stat_word                = '0;
        stat_word[STAT_INF_BIT]  = in_full;
        stat_word[STAT_OUTF_BIT] = out_full;
        stat_word[STAT_LOCK_BIT] = lock;
    end

    // Produce the strobes towards the two word slots.
    always_comb begin
        out_load = req.wr && !req.blocked && (req.sel == SEL_DATA);
        out_data = core_wdata;
        in_take  = req.rd && !req.blocked && (req.sel == SEL_DATA);
    end

    // Read mux: zero unless an unblocked read is in progress.
    always_comb begin
        core_rdata = '0;
        if (req.rd && !req.blocked)
            core_rdata = (req.sel == SEL_DATA) ? in_word : stat_word;
    end

    // Lock bit: the only status bit the core can write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock <= 1'b0;
        else if (req.wr && !req.blocked && (req.sel == SEL_STAT))
            lock <= core_wdata[STAT_LOCK_BIT];
    end

    // Error pulse: high for the cycle that follows a blocked access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            core_err <= 1'b0;
        else
            core_err <= req.blocked;
    end
endmodule

// File: rtl/dcc_host_if.sv
// Module: host-side strobe port. Maps the host strobes onto the slots and
// exposes the outbound word. Assumes the host keeps each strobe to one cycle per word.
module dcc_host_if #(
    parameter int W = 32
) (
    input  logic         host_wr_en,
    input  logic [W-1:0] host_wdata,
    input  logic         host_rd_en,
    input  logic [W-1:0] out_word,
    output logic         in_load,
    output logic [W-1:0] in_data,
    output logic         out_take,
    output logic [W-1:0] host_rdata
);
    // Pass the host strobes through and present the outbound word.
    always_comb begin
        in_load    = host_wr_en;
        in_data    = host_wdata;
        out_take   = host_rd_en;
        host_rdata = out_word;
    end
endmodule

// File: rtl/dcc_channel.sv
// Module: top of the debug mailbox channel. It instantiates the two word
// slots (inbound, outbound), the core port and the host port.
// Assumes one clock domain and a synchronous active-low reset.
module dcc_channel
    import dcc_pkg::*;
#(
    parameter int DATA_W = DCC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_en,
    input  logic              core_we,
    input  logic              core_addr,
    input  logic              core_priv,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_err,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd_en,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_in_full,
    output logic              host_out_full
);
    localparam int NSLOT   = 2;
    localparam int IDX_IN  = 0;
    localparam int IDX_OUT = 1;

    logic [NSLOT-1:0]             slot_load;
    logic [NSLOT-1:0]             slot_take;
    logic [NSLOT-1:0][DATA_W-1:0] slot_din;
    logic [NSLOT-1:0][DATA_W-1:0] slot_word;
    logic [NSLOT-1:0]             slot_full;
    logic [DATA_W-1:0]            in_word;
    logic [DATA_W-1:0]            out_word;
    logic                         in_take;
    logic                         lock;

    // One slot per direction.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        dcc_slot #(.W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (slot_load[g]),
            .load_data (slot_din[g]),
            .take      (slot_take[g]),
            .word      (slot_word[g]),
            .full      (slot_full[g])
        );
    end

    // Name the slot outputs per direction.
    always_comb begin
        in_word       = slot_word[IDX_IN];
        out_word      = slot_word[IDX_OUT];
        host_in_full  = slot_full[IDX_IN];
        host_out_full = slot_full[IDX_OUT];
        slot_take[IDX_IN] = in_take;
    end

    dcc_core_if #(.W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_en    (core_en),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_priv  (core_priv),
        .core_wdata (core_wdata),
        .in_word    (in_word),
        .in_full    (slot_full[IDX_IN]),
        .out_full   (slot_full[IDX_OUT]),
        .out_load   (slot_load[IDX_OUT]),
        .out_data   (slot_din[IDX_OUT]),
        .in_take    (in_take),
        .core_rdata (core_rdata),
        .core_err   (core_err),
        .lock       (lock)
    );

    dcc_host_if #(.W(DATA_W)) u_host (
        .host_wr_en (host_wr_en),
        .host_wdata (host_wdata),
        .host_rd_en (host_rd_en),
        .out_word   (out_word),
        .in_load    (slot_load[IDX_IN]),
        .in_data    (slot_din[IDX_IN]),
        .out_take   (slot_take[IDX_OUT]),
        .host_rdata (host_rdata)
    );
endmodule

// File: rtl/dcc_channel_chk.sv
// Checker: clocked properties for the debug mailbox channel, bound to the top.
module dcc_channel_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_en,
    input logic              core_we,
    input logic              core_addr,
    input logic              core_priv,
    input logic [DATA_W-1:0] core_wdata,
    input logic [DATA_W-1:0] core_rdata,
    input logic              core_err,
    input logic              host_wr_en,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_rd_en,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_in_full,
    input logic              host_out_full,
    input logic [DATA_W-1:0] in_word,
    input logic              lock
);
    logic blk, cdata_wr, cdata_rd;
    assign blk      = core_en && lock && !core_priv;
    assign cdata_wr = core_en && core_we && !core_addr && !blk;
    assign cdata_rd = core_en && !core_we && !core_addr && !blk;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!host_in_full && !host_out_full && !core_err && !lock));
    // R2
    out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cdata_wr |=> (host_out_full && host_rdata == $past(core_wdata)));
    // R4
    out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && !cdata_wr) |=> !host_out_full);
    // R5
    in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en |=> (host_in_full && in_word == $past(host_wdata)));
    // R10
    in_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && cdata_rd) |=> host_in_full);
    // R8
    blocked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk |=> core_err);
    // R8
    blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && !core_we) |-> (core_rdata == '0));
    // R8
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && core_we && !host_rd_en) |=> ($stable(host_rdata) && $stable(lock)
                                             && $stable(host_out_full)));
    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk |=> !core_err);
endmodule

bind dcc_channel dcc_channel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_en       (core_en),
    .core_we       (core_we),
    .core_addr     (core_addr),
    .core_priv     (core_priv),
    .core_wdata    (core_wdata),
    .core_rdata    (core_rdata),
    .core_err      (core_err),
    .host_wr_en    (host_wr_en),
    .host_wdata    (host_wdata),
    .host_rd_en    (host_rd_en),
    .host_rdata    (host_rdata),
    .host_in_full  (host_in_full),
    .host_out_full (host_out_full),
    .in_word       (in_word),
    .lock          (lock)
);

// File: tb/tb_dcc_channel.sv
`timescale 1ns/1ps
module tb_dcc_channel;
    localparam int W = 32;
    localparam int SWEEP = 4000;
    localparam int WD_CYCLES = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         core_en = 1'b0, core_we = 1'b0, core_addr = 1'b0, core_priv = 1'b0;
    logic [W-1:0] core_wdata = '0;
    logic [W-1:0] core_rdata;
    logic         core_err;
    logic         host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [W-1:0] host_wdata = '0;
    logic [W-1:0] host_rdata;
    logic         host_in_full, host_out_full;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state.
    logic [W-1:0] m_in = '0, m_out = '0;
    logic         m_inf = 1'b0, m_outf = 1'b0, m_lock = 1'b0, m_err = 1'b0;

    always #10 clk = ~clk;

    dcc_channel #(.DATA_W(W)) dut (.*);

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] stat_exp();
        return (W'(m_inf) << 30) | (W'(m_outf) << 29) | (W'(m_lock) << 12);
    endfunction

    // One cycle: drive, check the read data, clock, check the state.
    task automatic step(input string tag, input logic en, input logic we,
                        input logic addr, input logic priv, input logic [W-1:0] wd,
                        input logic hw, input logic [W-1:0] hwd, input logic hr);
        logic blk, cwd, cws, crd;
        logic [W-1:0] exp_rd;
        @(negedge clk);
        core_en = en; core_we = we; core_addr = addr; core_priv = priv;
        core_wdata = wd; host_wr_en = hw; host_wdata = hwd; host_rd_en = hr;
        blk = en && m_lock && !priv;
        cwd = en && we && !addr && !blk;
        cws = en && we && addr && !blk;
        crd = en && !we && !addr && !blk;
        exp_rd = '0;
        if (en && !we && !blk) exp_rd = addr ? stat_exp() : m_in;
        #1;
        check(tag, "core_rdata", core_rdata, exp_rd);
        if (hw) m_in = hwd;
        m_inf = hw ? 1'b1 : (crd ? 1'b0 : m_inf);
        if (cwd) m_out = wd;
        m_outf = cwd ? 1'b1 : (hr ? 1'b0 : m_outf);
        if (cws) m_lock = wd[12];
        m_err = blk;
        @(posedge clk); #1;
        check(tag, "host_in_full", W'(host_in_full), W'(m_inf));
        check(tag, "host_out_full", W'(host_out_full), W'(m_outf));
        check(tag, "host_rdata", host_rdata, m_out);
        check(tag, "core_err", W'(core_err), W'(m_err));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state at the ports
        check("R1", "host_in_full", W'(host_in_full), '0);
        check("R1", "host_out_full", W'(host_out_full), '0);
        check("R1", "host_rdata", host_rdata, '0);
        check("R1", "core_err", W'(core_err), '0);
        @(negedge clk); rst_n = 1'b1;
        step("R1_stat", 1, 0, 1, 0, '0, 0, '0, 0);
        // R6: read of an empty inbound word returns last word (zero) and flag stays clear
        step("R6", 1, 0, 0, 0, '0, 0, '0, 0);
        // R2 / R3: load outbound, then overwrite while full
        step("R2", 1, 1, 0, 0, 32'hCAFE_0001, 0, '0, 0);
        step("R3", 1, 1, 0, 0, 32'hCAFE_0002, 0, '0, 0);
        // R11: inbound traffic leaves the outbound side alone
        step("R11", 0, 0, 0, 0, '0, 1, 32'h1234_5678, 0);
        // R5: overwrite inbound while full, then core read clears it
        step("R5", 0, 0, 0, 0, '0, 1, 32'h8765_4321, 0);
        step("R7", 1, 0, 1, 0, '0, 0, '0, 0);
        step("R5", 1, 0, 0, 0, '0, 0, '0, 0);
        // R6: read again while empty returns the last word
        step("R6", 1, 0, 0, 0, '0, 0, '0, 0);
        // R4: host read clears outbound flag
        step("R4", 0, 0, 0, 0, '0, 0, '0, 1);
        // R10: same-cycle set and clear on both flags
        step("R10", 0, 0, 0, 0, '0, 1, 32'hAAAA_5555, 0);
        step("R10", 1, 0, 0, 1, '0, 1, 32'h5555_AAAA, 0);
        step("R10", 1, 1, 0, 0, 32'h0F0F_0F0F, 0, '0, 1);
        // R7: status write changes only the lock bit
        step("R7", 1, 1, 1, 1, 32'hFFFF_FFFF, 0, '0, 0);
        step("R7", 1, 0, 1, 1, '0, 0, '0, 0);
        // R8: unprivileged accesses are blocked
        step("R8", 1, 0, 1, 0, '0, 0, '0, 0);
        step("R8", 1, 1, 0, 0, 32'hDEAD_BEEF, 0, '0, 0);
        step("R8", 1, 1, 1, 0, '0, 0, '0, 0);
        step("R8", 1, 0, 0, 0, '0, 0, '0, 0);
        // R9: privileged access still works with lock set, error low
        step("R9", 1, 0, 0, 1, '0, 0, '0, 0);
        step("R9", 1, 1, 1, 1, '0, 0, '0, 0);
        step("R9", 1, 0, 1, 0, '0, 0, '0, 0);
        // Sweep over all strobe combinations with derived data
        for (int s = 0; s < SWEEP; s++) begin
            logic [W-1:0] h;
            h = W'(s) * 32'h9E37_79B1;
            step("R10_sweep", h[3], h[5], h[7], h[9], h ^ 32'h0000_1000 * W'(s % 2),
                 h[11], ~h + W'(s), h[13]);
        end
        // R1: assert reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1", "host_in_full", W'(host_in_full), '0);
        check("R1", "host_out_full", W'(host_out_full), '0);
        check("R1", "host_rdata", host_rdata, '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule